// File: doc/BRIEF.md
# Trace port configuration register file

This block holds the software-visible configuration of a trace output unit. A 32-bit register bus with a byte offset, a write enable, write data, a read strobe and read data reaches a small set of fixed offsets. Some offsets return constants describing the unit: the port widths it supports, its formatter status, a synchronisation counter that is always zero, the claim mask and a device identifier. Other offsets hold live settings: the current port width, an asynchronous clock prescaler, the output pin protocol and the formatter control bits. These settings leave the block as plain configuration outputs.

Two features go beyond plain storage. First, two claim offsets are aliased. One of them reads the claim mask and sets tag bits on a write. The other reads the current tag and clears tag bits on a write. Second, while the parallel protocol is selected, the formatter is forced on. During that time the formatter control offset reads a fixed value and the matching outputs are forced high. The stored value survives this period and reappears once a serial protocol is chosen.

Every access completes in a single cycle. A read strobe sampled on a clock edge presents the data on the following cycle. The data is the register contents as they stood before any write made in that same cycle.

Top module: `trcfg_regfile`

## Requirements
- R1: After reset the current port width is 0x1, the prescaler is 0, the protocol is 1 (serial Manchester), formatter control holds 0x102 (trigger insert on, continuous formatting on) and the claim tag is 0.
- R2: Constant offsets read fixed values: 0x000 reads 0xB (widths 1, 2 and 4 supported, width 3 not supported), 0x300 reads 0x8, 0x308 reads 0, 0xFA0 reads 0xF and 0xFC8 reads 0xCA0.
- R3: A write to 0x004 stores write-data bits 3:0 masked by 0xB, so bit 2 is never kept. The stored value drives port_size_o and reads back at 0x004.
- R4: A write to 0x010 stores write-data bits 12:0 as the prescaler on prescale_o. Reads return the prescaler with bits 31:13 at zero.
- R5: A write to 0x0F0 stores write-data bits 1:0 as the protocol on protocol_o. The codes are 0 for the parallel port, 1 for serial Manchester and 2 for serial NRZ. Upper bits read as zero.
- R6: A write to 0x304 stores bit 8 as trigger insert and bit 1 as continuous formatting. All other bits read as zero.
- R7: While the protocol is 0, a read of 0x304 returns 0x102 and both trig_insert_o and cont_fmt_o are 1. Writes to 0x304 made in this period are still stored, and the stored value is read and driven again once the protocol is not 0.
- R8: A write to 0xFA0 sets each claim tag bit i (i in 0..3) for which write-data bit i is 1. Other tag bits are unchanged.
- R9: A write to 0xFA4 clears each claim tag bit i for which write-data bit i is 1. A read of 0xFA4 returns the tag in bits 3:0 with the upper bits at zero.
- R10: Writes to the read-only offsets, to unmapped offsets and to unaligned offsets change no state. Reads of unmapped offsets return 0.
- R11: When rd_en is high at a clock edge, rd_data shows the value of the addressed offset from before that edge on the following cycle, even if a write to that offset occurs in the same cycle. When rd_en is low, rd_data is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 12 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, registered |
| port_size_o | output | 4 | One-hot current port width (bit0=1, bit1=2, bit3=4) |
| prescale_o | output | 13 | Asynchronous clock divider minus one |
| protocol_o | output | 2 | Pin protocol select |
| cont_fmt_o | output | 1 | Continuous formatting enable (forced in parallel mode) |
| trig_insert_o | output | 1 | Trigger insertion enable (forced in parallel mode) |

## Verification
Any corruption of the stored settings appears on the configuration outputs on the cycle right after the faulty write. It also appears in read data one cycle after a read strobe. A claim tag fault stays hidden until the tag offset is read, so the bench reads the tag after every claim access. A fault in the parallel-mode override shows up in two places. It is visible at once on the forced outputs. It also shows when the protocol returns to serial, because the stored formatter bits must then come back unchanged.

// File: rtl/trcfg_pkg.sv
package trcfg_pkg;

   // Offsets whose positions are fixed by software that decodes them
   localparam logic [11:0] OFF_SUPP    = 12'h000;
   localparam logic [11:0] OFF_CUR     = 12'h004;
   localparam logic [11:0] OFF_PRESC   = 12'h010;
   localparam logic [11:0] OFF_PROTO   = 12'h0F0;
   localparam logic [11:0] OFF_FSTAT   = 12'h300;
   localparam logic [11:0] OFF_FCTL    = 12'h304;
   localparam logic [11:0] OFF_SYNC    = 12'h308;
   localparam logic [11:0] OFF_CLMASK  = 12'hFA0;
   localparam logic [11:0] OFF_CLTAG   = 12'hFA4;
   localparam logic [11:0] OFF_DEVID   = 12'hFC8;

   localparam logic [1:0]  PROTO_PAR   = 2'd0;
   localparam logic [1:0]  PROTO_MANCH = 2'd1;
   localparam logic [1:0]  PROTO_NRZ   = 2'd2;

   localparam int          FCTL_TRIG_BIT = 8;
   localparam int          FCTL_CONT_BIT = 1;
   localparam logic [15:0] FCTL_FORCED   = 16'h0102;
   localparam logic [3:0]  FSTAT_VAL     = 4'h8;

   typedef struct packed {
      logic supp;
      logic cur;
      logic presc;
      logic proto;
      logic fstat;
      logic fctl;
      logic sync;
      logic clmask;
      logic cltag;
      logic devid;
   } sel_t;

endpackage

// File: rtl/trcfg_decode.sv
module trcfg_decode
   import trcfg_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output sel_t              sel_o,
   output logic              hit_o
);

   always_comb begin
      sel_o.supp   = (addr_i == ADDR_W'(OFF_SUPP));
      sel_o.cur    = (addr_i == ADDR_W'(OFF_CUR));
      sel_o.presc  = (addr_i == ADDR_W'(OFF_PRESC));
      sel_o.proto  = (addr_i == ADDR_W'(OFF_PROTO));
      sel_o.fstat  = (addr_i == ADDR_W'(OFF_FSTAT));
      sel_o.fctl   = (addr_i == ADDR_W'(OFF_FCTL));
      sel_o.sync   = (addr_i == ADDR_W'(OFF_SYNC));
      sel_o.clmask = (addr_i == ADDR_W'(OFF_CLMASK));
      sel_o.cltag  = (addr_i == ADDR_W'(OFF_CLTAG));
      sel_o.devid  = (addr_i == ADDR_W'(OFF_DEVID));
   end

   assign hit_o = |sel_o;

   always_comb begin
      assert ($onehot0(sel_o))
         else $error("assert_decode_onehot_R10: more than one offset selected");
   end

endmodule

// File: rtl/trcfg_ctrl.sv
module trcfg_ctrl
   import trcfg_pkg::*;
#(
   parameter int         DATA_W    = 32,
   parameter int         PRESC_W   = 13,
   parameter logic [3:0] SUPP_MASK = 4'hB
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_cur_i,
   input  logic               wr_presc_i,
   input  logic               wr_proto_i,
   input  logic               wr_fctl_i,
   input  logic [DATA_W-1:0]  wr_data_i,
   output logic [3:0]         port_q_o,
   output logic [PRESC_W-1:0] presc_q_o,
   output logic [1:0]         proto_q_o,
   output logic               trig_q_o,
   output logic               cont_q_o
);

   logic unused_wdata;
   assign unused_wdata = ^wr_data_i;

   // Only widths marked supported own a storage bit
   for (genvar i = 0; i < 4; i++) begin : g_port
      if (SUPP_MASK[i]) begin : g_impl
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)       port_q_o[i] <= (i == 0);
            else if (wr_cur_i) port_q_o[i] <= wr_data_i[i];
         end
      end else begin : g_tie
         assign port_q_o[i] = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         presc_q_o <= '0;
         proto_q_o <= PROTO_MANCH;
         trig_q_o  <= 1'b1;
         cont_q_o  <= 1'b1;
      end else begin
         if (wr_presc_i) presc_q_o <= wr_data_i[PRESC_W-1:0];
         if (wr_proto_i) proto_q_o <= wr_data_i[1:0];
         if (wr_fctl_i) begin
            trig_q_o <= wr_data_i[FCTL_TRIG_BIT];
            cont_q_o <= wr_data_i[FCTL_CONT_BIT];
         end
      end
   end

   assert_port_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_cur_i |=> $stable(port_q_o));

   assert_port_supported_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_cur_i |=> port_q_o == ($past(wr_data_i[3:0]) & SUPP_MASK));

   assert_fctl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_fctl_i |=> $stable(trig_q_o) && $stable(cont_q_o));

   assert_proto_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_proto_i |=> $stable(proto_q_o));

endmodule

// File: rtl/trcfg_claim.sv
module trcfg_claim #(
   parameter int DATA_W     = 32,
   parameter int CLAIM_BITS = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  set_i,
   input  logic                  clr_i,
   input  logic [DATA_W-1:0]     wr_data_i,
   output logic [CLAIM_BITS-1:0] tag_o
);

   logic unused_wdata;
   assign unused_wdata = ^wr_data_i;

   for (genvar i = 0; i < CLAIM_BITS; i++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                         tag_o[i] <= 1'b0;
         else if (set_i && wr_data_i[i])      tag_o[i] <= 1'b1;
         else if (clr_i && wr_data_i[i])      tag_o[i] <= 1'b0;
      end
   end

   assert_claim_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> (tag_o & $past(wr_data_i[CLAIM_BITS-1:0])) == $past(wr_data_i[CLAIM_BITS-1:0]));

   assert_claim_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !set_i |=> (tag_o & $past(wr_data_i[CLAIM_BITS-1:0])) == '0);

   assert_claim_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !set_i && !clr_i |=> $stable(tag_o));

endmodule

// File: rtl/trcfg_regfile.sv
module trcfg_regfile
   import trcfg_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter int          PRESC_W    = 13,
   parameter int          CLAIM_BITS = 4,
   parameter logic [3:0]  SUPP_MASK  = 4'hB,
   parameter logic [31:0] DEV_ID     = 32'h0000_0CA0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   output logic [DATA_W-1:0]  rd_data,
   output logic [3:0]         port_size_o,
   output logic [PRESC_W-1:0] prescale_o,
   output logic [1:0]         protocol_o,
   output logic               cont_fmt_o,
   output logic               trig_insert_o
);

   localparam logic [DATA_W-1:0] FORCED_W = DATA_W'(FCTL_FORCED);
   localparam logic [DATA_W-1:0] DEVID_W  = DATA_W'(DEV_ID);

   if (ADDR_W < 12) begin : g_chk_addr
      $error("ADDR_W must cover offset 0xFC8");
   end
   if (DATA_W < 16) begin : g_chk_data
      $error("DATA_W must hold the device identifier and bit 8");
   end
   if (PRESC_W < 1 || PRESC_W > DATA_W) begin : g_chk_presc
      $error("PRESC_W out of range");
   end
   if (CLAIM_BITS < 1 || CLAIM_BITS > DATA_W) begin : g_chk_claim
      $error("CLAIM_BITS out of range");
   end
   if (!SUPP_MASK[0]) begin : g_chk_supp
      $error("reset width 1 must be supported");
   end

   sel_t sel;
   logic hit;

   trcfg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr_i (addr),
      .sel_o  (sel),
      .hit_o  (hit)
   );

   logic [3:0]            port_q;
   logic [PRESC_W-1:0]    presc_q;
   logic [1:0]            proto_q;
   logic                  trig_q;
   logic                  cont_q;
   logic [CLAIM_BITS-1:0] tag_q;

   trcfg_ctrl #(
      .DATA_W    (DATA_W),
      .PRESC_W   (PRESC_W),
      .SUPP_MASK (SUPP_MASK)
   ) u_ctrl (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .wr_cur_i   (wr_en && sel.cur),
      .wr_presc_i (wr_en && sel.presc),
      .wr_proto_i (wr_en && sel.proto),
      .wr_fctl_i  (wr_en && sel.fctl),
      .wr_data_i  (wr_data),
      .port_q_o   (port_q),
      .presc_q_o  (presc_q),
      .proto_q_o  (proto_q),
      .trig_q_o   (trig_q),
      .cont_q_o   (cont_q)
   );

   trcfg_claim #(
      .DATA_W     (DATA_W),
      .CLAIM_BITS (CLAIM_BITS)
   ) u_claim (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .set_i     (wr_en && sel.clmask),
      .clr_i     (wr_en && sel.cltag),
      .wr_data_i (wr_data),
      .tag_o     (tag_q)
   );

   logic par_mode;
   assign par_mode = (proto_q == PROTO_PAR);

   assign port_size_o   = port_q;
   assign prescale_o    = presc_q;
   assign protocol_o    = proto_q;
   assign cont_fmt_o    = par_mode | cont_q;
   assign trig_insert_o = par_mode | trig_q;

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (sel.supp)   rd_val[3:0] = SUPP_MASK;
      if (sel.cur)    rd_val[3:0] = port_q;
      if (sel.presc)  rd_val[PRESC_W-1:0] = presc_q;
      if (sel.proto)  rd_val[1:0] = proto_q;
      if (sel.fstat)  rd_val[3:0] = FSTAT_VAL;
      if (sel.fctl) begin
         if (par_mode) begin
            rd_val = FORCED_W;
         end else begin
            rd_val[FCTL_TRIG_BIT] = trig_q;
            rd_val[FCTL_CONT_BIT] = cont_q;
         end
      end
      if (sel.clmask) rd_val[CLAIM_BITS-1:0] = '1;
      if (sel.cltag)  rd_val[CLAIM_BITS-1:0] = tag_q;
      if (sel.devid)  rd_val = DEVID_W;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_val;
      else            rd_data <= '0;
   end

   assert_override_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && sel.fctl && protocol_o == PROTO_PAR |=> rd_data == FORCED_W);

   assert_override_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
      protocol_o == PROTO_PAR |-> cont_fmt_o && trig_insert_o);

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !hit |=> rd_data == '0);

   assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> rd_data == '0);

   assert_devid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && sel.devid |=> rd_data == DEVID_W);

endmodule

// File: tb/tb_trcfg_regfile.sv
module tb_trcfg_regfile;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [3:0]  port_size_o;
   logic [12:0] prescale_o;
   logic [1:0]  protocol_o;
   logic        cont_fmt_o;
   logic        trig_insert_o;

   trcfg_regfile dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .addr          (addr),
      .wr_en         (wr_en),
      .wr_data       (wr_data),
      .rd_en         (rd_en),
      .rd_data       (rd_data),
      .port_size_o   (port_size_o),
      .prescale_o    (prescale_o),
      .protocol_o    (protocol_o),
      .cont_fmt_o    (cont_fmt_o),
      .trig_insert_o (trig_insert_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // Reference state
   logic [3:0]  m_port;
   logic [12:0] m_presc;
   logic [1:0]  m_proto;
   logic        m_trig;
   logic        m_cont;
   logic [3:0]  m_tag;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         12'h000: return 32'hB;
         12'h004: return {28'd0, m_port};
         12'h010: return {19'd0, m_presc};
         12'h0F0: return {30'd0, m_proto};
         12'h300: return 32'h8;
         12'h304: return (m_proto == 2'd0) ? 32'h102 : ({23'd0, m_trig, 8'd0} | {30'd0, m_cont, 1'b0});
         12'h308: return 32'h0;
         12'hFA0: return 32'hF;
         12'hFA4: return {28'd0, m_tag};
         12'hFC8: return 32'hCA0;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [11:0] a);
      case (a)
         12'h004: return "R3";
         12'h010: return "R4";
         12'h0F0: return "R5";
         12'h304: return "R6/R7";
         12'hFA4: return "R9";
         12'h000, 12'h300, 12'h308, 12'hFA0, 12'hFC8: return "R2";
         default: return "R10";
      endcase
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      case (a)
         12'h004: m_port  = d[3:0] & 4'hB;
         12'h010: m_presc = d[12:0];
         12'h0F0: m_proto = d[1:0];
         12'h304: begin m_trig = d[8]; m_cont = d[1]; end
         12'hFA0: m_tag   = m_tag | d[3:0];
         12'hFA4: m_tag   = m_tag & ~d[3:0];
         default: ;
      endcase
   endtask

   task automatic check_outputs(input string req);
      logic forced;
      forced = (m_proto == 2'd0);
      check({req, " port_size_o"}, {28'd0, port_size_o}, {28'd0, m_port});
      check({req, " prescale_o"}, {19'd0, prescale_o}, {19'd0, m_presc});
      check({req, " protocol_o"}, {30'd0, protocol_o}, {30'd0, m_proto});
      check({req, " cont_fmt_o"}, {31'd0, cont_fmt_o}, {31'd0, forced | m_cont});
      check({req, " trig_insert_o"}, {31'd0, trig_insert_o}, {31'd0, forced | m_trig});
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read_check(input logic [11:0] a, input string req);
      logic [31:0] e;
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      e = exp_read(a);
      @(negedge clk);
      rd_en = 1'b0;
      check(req, rd_data, e);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed_dummy;
      logic [11:0] addr_pool [13];
      addr_pool = '{12'h000, 12'h004, 12'h010, 12'h0F0, 12'h300, 12'h304, 12'h308,
                    12'hFA0, 12'hFA4, 12'hFC8, 12'h008, 12'h005, 12'h7FC};
      seed_dummy = $urandom(32'd20240611);

      m_port = 4'h1; m_presc = '0; m_proto = 2'd1; m_trig = 1'b1; m_cont = 1'b1; m_tag = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state at the outputs and through reads
      check_outputs("R1");
      bus_read_check(12'h004, "R1 port");
      bus_read_check(12'h010, "R1 presc");
      bus_read_check(12'h0F0, "R1 proto");
      bus_read_check(12'h304, "R1 fctl");
      bus_read_check(12'hFA4, "R1 tag");

      // R2: constant offsets
      bus_read_check(12'h000, "R2 supp");
      bus_read_check(12'h300, "R2 fstat");
      bus_read_check(12'h308, "R2 sync");
      bus_read_check(12'hFA0, "R2 mask");
      bus_read_check(12'hFC8, "R2 devid");

      // R11: idle cycle after a read returns zero
      @(negedge clk);
      check("R11 idle", rd_data, 32'h0);

      // R3: width 3 bit is dropped
      bus_write(12'h004, 32'h0000_0004);
      check_outputs("R3");
      bus_read_check(12'h004, "R3 unsupported");
      bus_write(12'h004, 32'hFFFF_FFF8);
      check_outputs("R3");
      bus_read_check(12'h004, "R3 width4");

      // R4: prescaler width and upper zero
      bus_write(12'h010, 32'hFFFF_FFFF);
      check_outputs("R4");
      bus_read_check(12'h010, "R4 full");

      // R6: formatter bits stored, others dropped
      bus_write(12'h304, 32'hFFFF_FEFD);
      check_outputs("R6");
      bus_read_check(12'h304, "R6 clear both");

      // R5/R7: parallel mode override and revert
      bus_write(12'h0F0, 32'hFFFF_FFFC);
      check_outputs("R7");
      bus_read_check(12'h0F0, "R5 parallel");
      bus_read_check(12'h304, "R7 forced");
      bus_write(12'h304, 32'h0000_0100);
      check_outputs("R7");
      bus_read_check(12'h304, "R7 forced after write");
      bus_write(12'h0F0, 32'h0000_0002);
      check_outputs("R7");
      bus_read_check(12'h304, "R7 revert");
      bus_read_check(12'h0F0, "R5 nrz");

      // R8/R9: claim set and clear
      bus_write(12'hFA0, 32'hFFFF_FFF5);
      bus_read_check(12'hFA4, "R8 set");
      bus_read_check(12'hFA0, "R8 mask stays");
      bus_write(12'hFA0, 32'h0000_0002);
      bus_read_check(12'hFA4, "R8 set more");
      bus_write(12'hFA4, 32'hFFFF_FFF4);
      bus_read_check(12'hFA4, "R9 clear");

      // R10: writes to read-only, unmapped and unaligned offsets
      bus_write(12'h000, 32'h0);
      bus_write(12'h300, 32'hFFFF_FFFF);
      bus_write(12'h308, 32'hFFFF_FFFF);
      bus_write(12'hFC8, 32'h0);
      bus_write(12'h005, 32'h0000_0001);
      bus_write(12'h011, 32'h0000_0000);
      check_outputs("R10");
      bus_read_check(12'h000, "R10 supp");
      bus_read_check(12'h308, "R10 sync");
      bus_read_check(12'hFC8, "R10 devid");
      bus_read_check(12'h004, "R10 port");
      bus_read_check(12'h008, "R10 unmapped read");
      bus_read_check(12'hFA4, "R10 tag");

      // R11: read and write in the same cycle returns the old value
      begin
         logic [31:0] e;
         @(negedge clk);
         addr = 12'h010; wr_data = 32'h0000_1234; wr_en = 1'b1; rd_en = 1'b1;
         e = exp_read(12'h010);
         @(negedge clk);
         wr_en = 1'b0; rd_en = 1'b0;
         check("R11 read before write", rd_data, e);
         model_write(12'h010, 32'h0000_1234);
         check_outputs("R11");
      end

      // Random mix
      for (int k = 0; k < 400; k++) begin
         logic [11:0] a;
         logic [31:0] d;
         a = addr_pool[$urandom_range(12, 0)];
         d = $urandom;
         if ($urandom_range(1, 0) == 0) begin
            bus_write(a, d);
            check_outputs("R3/R4/R5/R7 random");
         end else begin
            bus_read_check(a, {req_of(a), " random"});
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule